// File: doc/BRIEF.md
# Temperature Alarm Interrupt Controller

This block watches a stream of finished temperature conversions and raises an interrupt line when a reading climbs past a programmable hot limit. A second, lower limit provides hysteresis and decides when a latched alarm is allowed to fire again. Each conversion arrives as a one-cycle strobe with a signed 8-bit reading. All limit comparisons happen only on that strobe. Between conversions, the alarm state changes only through software: a status-register read strobe or a clear-command strobe.

Three behaviours can be selected. One-shot latched mode fires once and then stays silent until a reading drops under the hysteresis limit. Repeating latched mode fires again on every conversion for as long as the temperature has not dropped under the hysteresis limit since it last went hot. Comparator mode follows the hot limit live, but software can still knock the line down. A sticky status flag records that a hot reading was seen, and a status read clears it.

Top module: `temp_alarm_irq`

## Requirements
- R1: After reset, irqOut and statusFlag are 0 and the one-shot alarm is armed.
- R2: Readings and both limits are compared as two's-complement signed values, and only in a cycle where convDone is 1. With convDone, statusRead and clearCmd all 0, irqOut and statusFlag hold their values.
- R3: In one-shot mode (modeSel 01), an armed alarm and a reading strictly greater than hotLimit set irqOut, and the alarm is disarmed. irqOut then stays 1 through later conversions until a statusRead or clearCmd pulse.
- R4: In one-shot mode, a disarmed alarm cannot set irqOut. Only a reading strictly below hystLimit re-arms it, and a reading equal to hystLimit does not.
- R5: In default mode (modeSel 00), a reading strictly greater than hotLimit sets irqOut, and a reading equal to hotLimit does not. After a clear, every later conversion sets irqOut again while no reading strictly below hystLimit has arrived since the last hot reading. A reading equal to hystLimit keeps this repeating.
- R6: In default mode, a reading strictly below hystLimit ends the repetition. Later readings at or below hotLimit then leave irqOut at 0.
- R7: In comparator mode (modeSel 10), every conversion sets irqOut to 1 if the reading is above hotLimit, and to 0 otherwise. A reading equal to hotLimit gives 0.
- R8: A statusRead or clearCmd pulse drives irqOut to 0 in every mode. When such a pulse coincides with a conversion that would set irqOut, the conversion wins in default and comparator modes and the pulse wins in one-shot mode. In one-shot mode the alarm is still disarmed in that case.
- R9: statusFlag is set by any conversion above hotLimit, in any mode. Only statusRead clears it; clearCmd leaves it alone. A hot conversion in the same cycle as statusRead leaves it at 1.
- R10: modeSel 11 behaves exactly as default mode.
- R11: irqOut and statusFlag are registered outputs. They show the effect of a cycle's inputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| convDone | input | 1 | One-cycle strobe: convTemp holds a finished reading |
| convTemp | input | 8 | Signed temperature reading |
| hotLimit | input | 8 | Signed hot limit |
| hystLimit | input | 8 | Signed hysteresis (low) limit |
| modeSel | input | 2 | 00 default, 01 one-shot, 10 comparator, 11 default |
| statusRead | input | 1 | Strobe: status register is being read |
| clearCmd | input | 1 | Strobe: software clear command |
| irqOut | output | 1 | Active-high interrupt line |
| statusFlag | output | 1 | Sticky hot-event status bit |

## Verification
Directed sequences place readings exactly on the hot limit, exactly on the hysteresis limit, and one step either side of each. This separates strict from non-strict comparisons and shows which readings re-arm or stop the repeats in the two latched modes. Negative limits against positive and negative readings separate signed from unsigned compares. Clear and read strobes are issued both alone and in the same cycle as a hot conversion, which exposes the per-mode priority and which strobe touches the status flag. Long seeded random runs then switch modes, move the limits and mix strobes, and every cycle is compared against a bench model of the requirements.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

  typedef enum logic [1:0] {
    MODE_DEFAULT = 2'b00,
    MODE_ONESHOT = 2'b01,
    MODE_COMPARE = 2'b10,
    MODE_ALTDEF  = 2'b11
  } alarmMode_e;

  // Per-cycle strobes passed from the comparison datapath to the control
  typedef struct packed {
    logic sample;    // a conversion result is present this cycle
    logic hotHit;    // reading strictly above hot limit (qualified by sample)
    logic coolHit;   // reading strictly below hysteresis limit (qualified by sample)
    logic clearReq;  // read or clear command, either one
    logic readReq;   // status register read
  } alarmStrobes_t;

endpackage

// File: rtl/temp_alarm_dp.sv
module temp_alarm_dp
  import temp_alarm_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic              convDone,
  input  logic [TEMP_W-1:0] convTemp,
  input  logic [TEMP_W-1:0] hotLimit,
  input  logic [TEMP_W-1:0] hystLimit,
  input  logic              statusRead,
  input  logic              clearCmd,
  output alarmStrobes_t     strb
);

  logic aboveHot;
  logic belowHyst;

  generate
    if (SIGNED_CMP) begin : g_signedCmp
      assign aboveHot  = $signed(convTemp) > $signed(hotLimit);
      assign belowHyst = $signed(convTemp) < $signed(hystLimit);
    end else begin : g_unsignedCmp
      assign aboveHot  = convTemp > hotLimit;
      assign belowHyst = convTemp < hystLimit;
    end
  endgenerate

  always_comb begin
    strb.sample   = convDone;
    strb.hotHit   = convDone & aboveHot;
    strb.coolHit  = convDone & belowHyst;
    strb.clearReq = statusRead | clearCmd;
    strb.readReq  = statusRead;
  end

endmodule

// File: rtl/temp_alarm_ctrl.sv
module temp_alarm_ctrl
  import temp_alarm_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    modeSel,
  input  alarmStrobes_t strb,
  output logic          irqOut,
  output logic          statusFlag
);

  logic       irqQ, irqNext;
  logic       armedQ, armedNext;
  logic       hotZoneQ, hotZoneNext;
  logic       statusQ, statusNext;
  alarmMode_e effMode;
  logic       fireOne;
  logic       fireDef;

  always_comb effMode = (modeSel == 2'b11) ? MODE_DEFAULT : alarmMode_e'(modeSel);

  assign fireOne = (effMode == MODE_ONESHOT) & strb.hotHit & armedQ;
  assign fireDef = strb.hotHit | (strb.sample & hotZoneQ & ~strb.coolHit);

  always_comb begin
    irqNext = irqQ;
    case (effMode)
      MODE_ONESHOT: begin
        if (fireOne)       irqNext = 1'b1;
        if (strb.clearReq) irqNext = 1'b0;
      end
      MODE_COMPARE: begin
        if (strb.sample)   irqNext = strb.hotHit;
        if (strb.clearReq && !strb.hotHit) irqNext = 1'b0;
      end
      default: begin
        if (strb.clearReq) irqNext = 1'b0;
        if (fireDef)       irqNext = 1'b1;
      end
    endcase
  end

  always_comb begin
    armedNext   = armedQ;
    hotZoneNext = hotZoneQ;
    if (strb.sample) begin
      armedNext   = strb.coolHit | (armedQ & ~fireOne);
      hotZoneNext = strb.hotHit | (hotZoneQ & ~strb.coolHit);
    end
  end

  always_comb begin
    statusNext = statusQ;
    if (strb.readReq) statusNext = 1'b0;
    if (strb.hotHit)  statusNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ     <= 1'b0;
      armedQ   <= 1'b1;
      hotZoneQ <= 1'b0;
      statusQ  <= 1'b0;
    end else begin
      irqQ     <= irqNext;
      armedQ   <= armedNext;
      hotZoneQ <= hotZoneNext;
      statusQ  <= statusNext;
    end
  end

  assign irqOut     = irqQ;
  assign statusFlag = statusQ;

  // R4: a disarmed one-shot alarm with the line low stays low
  p_oneshot_silent_r4: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == MODE_ONESHOT && !armedQ && !irqQ) |=> !irqOut);

  // R8: a lone clear or read with no conversion always drops the line
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearReq && !strb.sample) |=> !irqOut);

  // R2: with no conversion and no software strobe, the outputs hold
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sample && !strb.clearReq) |=> ($stable(irqOut) && $stable(statusFlag)));

  // R7: the comparator follows the hot compare when no clear is pending
  p_compare_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == MODE_COMPARE && strb.sample && !strb.clearReq) |=> (irqOut == $past(strb.hotHit)));

  // R9: any hot conversion leaves the status flag set
  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.hotHit |=> statusFlag);

  // R5: a hot conversion in default mode always leaves the line set
  p_default_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
    (effMode == MODE_DEFAULT && strb.hotHit) |=> irqOut);

endmodule

// File: rtl/temp_alarm_irq.sv
module temp_alarm_irq
  import temp_alarm_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [TEMP_W-1:0] convTemp,
  input  logic [TEMP_W-1:0] hotLimit,
  input  logic [TEMP_W-1:0] hystLimit,
  input  logic [1:0]        modeSel,
  input  logic              statusRead,
  input  logic              clearCmd,
  output logic              irqOut,
  output logic              statusFlag
);

  alarmStrobes_t strb;

  temp_alarm_dp #(
    .TEMP_W     (TEMP_W),
    .SIGNED_CMP (SIGNED_CMP)
  ) dp_i (
    .convDone   (convDone),
    .convTemp   (convTemp),
    .hotLimit   (hotLimit),
    .hystLimit  (hystLimit),
    .statusRead (statusRead),
    .clearCmd   (clearCmd),
    .strb       (strb)
  );

  temp_alarm_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .strb       (strb),
    .irqOut     (irqOut),
    .statusFlag (statusFlag)
  );

endmodule

// File: tb/temp_alarm_irq_tb_top.sv
`timescale 1ns/1ps
module temp_alarm_irq_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       convDone;
  logic [7:0] convTemp;
  logic [7:0] hotLimit;
  logic [7:0] hystLimit;
  logic [1:0] modeSel;
  logic       statusRead;
  logic       clearCmd;
  logic       irqOut;
  logic       statusFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  bit mIrq, mArmed, mZone, mStatus;

  always #4 clk = ~clk;

  temp_alarm_irq dut_i (
    .clk(clk), .rstN(rstN), .convDone(convDone), .convTemp(convTemp),
    .hotLimit(hotLimit), .hystLimit(hystLimit), .modeSel(modeSel),
    .statusRead(statusRead), .clearCmd(clearCmd),
    .irqOut(irqOut), .statusFlag(statusFlag)
  );

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // model of the requirements, applied once per clock edge
  task automatic modelStep();
    bit hot, cool, clr, fire;
    int m;
    hot  = convDone && ($signed(convTemp) > $signed(hotLimit));
    cool = convDone && ($signed(convTemp) < $signed(hystLimit));
    clr  = statusRead || clearCmd;
    m    = (modeSel == 2'b11) ? 0 : int'(modeSel);
    if (m == 1) begin
      fire = hot && mArmed;
      if (fire) mIrq = 1;
      if (clr) mIrq = 0;
      if (convDone) mArmed = cool || (mArmed && !fire);
    end else begin
      if (convDone) mArmed = cool || mArmed;
      if (m == 2) begin
        if (convDone) mIrq = hot;
        if (clr && !hot) mIrq = 0;
      end else begin
        if (clr) mIrq = 0;
        if (hot || (convDone && mZone && !cool)) mIrq = 1;
      end
    end
    if (convDone) mZone = hot || (mZone && !cool);
    if (statusRead) mStatus = 0;
    if (hot) mStatus = 1;
  endtask

  // drive one cycle of inputs, clock it, compare at the next falling edge
  task automatic cyc(input bit cd, input int t, input bit rd, input bit clr,
                     input string req, input bit chk);
    convDone = cd; convTemp = 8'(t); statusRead = rd; clearCmd = clr;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    convDone = 0; statusRead = 0; clearCmd = 0;
    if (chk) begin
      check(req, irqOut, mIrq, "irqOut");
      check(req, statusFlag, mStatus, "statusFlag");
    end
  endtask

  task automatic expectIrq(input string req, input bit exp);
    check(req, irqOut, exp, "irqOut directed");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 0; convDone = 0; convTemp = 0; statusRead = 0; clearCmd = 0;
    hotLimit = 8'd50; hystLimit = 8'd40; modeSel = 2'b01;
    repeat (3) @(negedge clk);
    rstN = 1;
    mIrq = 0; mArmed = 1; mZone = 0; mStatus = 0;
    // R1 reset state
    check("R1", irqOut, 1'b0, "irqOut after reset");
    check("R1", statusFlag, 1'b0, "statusFlag after reset");

    // one-shot mode
    cyc(1, 51, 0, 0, "R3", 1); expectIrq("R3", 1); // R11 visible after one edge
    check("R9", statusFlag, 1'b1, "status set on hot");
    cyc(0, 0, 0, 0, "R2", 1); cyc(0, 0, 0, 0, "R2", 1); expectIrq("R2", 1);
    cyc(1, 45, 0, 0, "R3", 1); expectIrq("R3", 1);
    cyc(0, 0, 1, 0, "R3", 1); expectIrq("R3", 0);
    check("R9", statusFlag, 1'b0, "status cleared by read");
    cyc(1, 60, 0, 0, "R4", 1); expectIrq("R4", 0);
    cyc(1, 40, 0, 0, "R4", 1); cyc(1, 60, 0, 0, "R4", 1); expectIrq("R4", 0);
    cyc(1, 39, 0, 0, "R4", 1); cyc(1, 60, 0, 0, "R4", 1); expectIrq("R4", 1);
    cyc(0, 0, 0, 1, "R8", 1); expectIrq("R8", 0);
    check("R9", statusFlag, 1'b1, "clearCmd leaves status");
    cyc(1, 30, 0, 0, "R4", 1);
    cyc(1, 60, 0, 1, "R8", 1); expectIrq("R8", 0);
    cyc(1, 60, 0, 0, "R8", 1); expectIrq("R8", 0);

    // default mode
    modeSel = 2'b00;
    cyc(1, 30, 0, 0, "R6", 1);
    cyc(1, 50, 0, 0, "R5", 1); expectIrq("R5", 0);
    cyc(1, 51, 0, 0, "R5", 1); expectIrq("R5", 1);
    cyc(0, 0, 0, 1, "R8", 1); expectIrq("R8", 0);
    cyc(1, 45, 0, 0, "R5", 1); expectIrq("R5", 1);
    cyc(0, 0, 0, 1, "R8", 1);
    cyc(1, 40, 0, 0, "R5", 1); expectIrq("R5", 1);
    cyc(0, 0, 1, 0, "R8", 1);
    cyc(1, 39, 0, 0, "R6", 1); expectIrq("R6", 0);
    cyc(1, 45, 0, 0, "R6", 1); expectIrq("R6", 0);
    cyc(1, 60, 1, 0, "R8", 1); expectIrq("R8", 1);
    check("R9", statusFlag, 1'b1, "hot wins over read");

    // mode 11 acts as default
    modeSel = 2'b11;
    cyc(0, 0, 0, 1, "R10", 1);
    cyc(1, 45, 0, 0, "R10", 1); expectIrq("R10", 1);

    // comparator mode
    modeSel = 2'b10;
    cyc(1, 60, 0, 0, "R7", 1); expectIrq("R7", 1);
    cyc(1, 50, 0, 0, "R7", 1); expectIrq("R7", 0);
    cyc(1, 55, 0, 0, "R7", 1);
    cyc(0, 0, 0, 1, "R8", 1); expectIrq("R8", 0);
    cyc(1, 55, 0, 1, "R8", 1); expectIrq("R8", 1);
    cyc(1, 20, 0, 0, "R7", 1); expectIrq("R7", 0);

    // R2 signed compare: -5 is below 10 signed, above it unsigned
    hotLimit = 8'd10; hystLimit = 8'(-20);
    cyc(1, -5, 0, 0, "R2", 1); expectIrq("R2", 0);
    cyc(1, 127, 0, 0, "R2", 1); expectIrq("R2", 1);
    cyc(1, -128, 0, 0, "R2", 1); expectIrq("R2", 0);

    // seeded random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int h;
      if ((i % 97) == 0) begin
        h = int'($urandom_range(200)) - 100;
        hotLimit  = 8'(h);
        hystLimit = 8'(h - int'($urandom_range(20)));
        modeSel   = 2'($urandom_range(3));
      end
      cyc($urandom_range(2) != 0, int'($urandom_range(255)) - 128,
          $urandom_range(9) == 0, $urandom_range(9) == 0, "R2", 1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule